// File: doc/BRIEF.md
# Integer ALU with Signed Multiply and Divide

This block is the combinational arithmetic unit of a small RISC-V style integer core. It takes two 32-bit operands and a 4-bit operation code, and it returns one 32-bit result in the same cycle. The core chooses whether operand B carries the second source register or a sign-extended immediate before the value reaches this block, so the unit itself never sees that choice.

It provides wrapping add and subtract, left, logical-right and arithmetic-right shifts, signed and unsigned less-than tests, the three bitwise operations, a signed multiply that keeps the low word of the product, and a single-cycle signed divide. Divide by zero and the one overflowing quotient both have fixed results, so the core never sees an undefined value. Operation codes with no assigned function give zero.

Top module: `int_alu`

## Requirements
- R1: Operation code 4'd0 gives a + b modulo 2^32.
- R2: Operation code 4'd1 gives a − b modulo 2^32.
- R3: Operation codes 4'd2 (shift left) and 4'd6 (logical shift right, zero fill) move a by the amount in b[4:0], and bits b[31:5] have no effect on the result.
- R4: Operation code 4'd7 shifts a right by b[4:0] and fills the vacated upper bits with a[31].
- R5: Operation code 4'd3 gives 1 when a is less than b as two's-complement values, and 0 otherwise.
- R6: Operation code 4'd4 gives 1 when a is less than b as unsigned values, and 0 otherwise.
- R7: Operation codes 4'd5, 4'd8 and 4'd9 give a XOR b, a OR b and a AND b, in that order.
- R8: Operation code 4'd10 gives bits [31:0] of the 64-bit product of a and b, both taken as signed.
- R9: Operation code 4'd11 gives the signed quotient a / b, rounded toward zero.
- R10: Under operation code 4'd11, b equal to zero gives 32'hFFFF_FFFF for any a.
- R11: Under operation code 4'd11, a = 32'h8000_0000 with b = 32'hFFFF_FFFF gives 32'h8000_0000.
- R12: Operation codes 4'd12 through 4'd15 give a result of zero for any operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, register value or immediate chosen outside the block |
| op_i | input | 4 | Operation code |
| y_o | output | 32 | Result |

## Verification
Add and subtract are tried across the carry and borrow wrap points, so a missing carry-in on the shared adder shows up. Shifts use amounts 0, 1, 31 and values with junk in b[31:5]: the junk separates a correct 5-bit amount from a full-width one, and a negative a separates the arithmetic fill from a zero fill. The compares use operand pairs whose signed and unsigned order disagree, which is the only way to tell SLT from SLTU. Multiply and divide are tried with every sign combination, inexact quotients to confirm rounding toward zero, a zero divisor, and the single overflowing quotient.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int XLEN_DEFAULT = 32;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_SLL  = 4'd2,
        OP_SLT  = 4'd3,
        OP_SLTU = 4'd4,
        OP_XOR  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_OR   = 4'd8,
        OP_AND  = 4'd9,
        OP_MUL  = 4'd10,
        OP_DIV  = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_LOGIC = 2'd1,
        SH_ARITH = 2'd2
    } shift_kind_e;

    typedef struct packed {
        logic lt_signed;
        logic lt_unsigned;
    } cmp_flags_t;

    // True for the codes that route through the adder in subtract mode
    function automatic logic needs_subtract(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import int_alu_pkg::*;
#(
    parameter int W = XLEN_DEFAULT
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output cmp_flags_t   flags
);
    logic [W-1:0] b_eff;
    logic         carry;

    assign b_eff        = sub ? ~b : b;
    assign {carry, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};

    // In subtract mode a borrow (no carry out) means a < b unsigned
    always_comb begin
        flags.lt_unsigned = ~carry;
        flags.lt_signed   = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import int_alu_pkg::*;
#(
    parameter int W   = XLEN_DEFAULT,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amount,
    input  shift_kind_e    kind,
    output logic [W-1:0]   y
);
    logic [W-1:0] a_rev;
    logic [W-1:0] core_in;
    logic [W-1:0] core_out;
    logic [W-1:0] core_rev;
    logic         fill;

    // Left shifts reuse the right shifter on a bit-reversed operand
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign a_rev[i]    = a[W-1-i];
        assign core_rev[i] = core_out[W-1-i];
    end

    assign core_in  = (kind == SH_LEFT) ? a_rev : a;
    assign fill     = (kind == SH_ARITH) ? a[W-1] : 1'b0;
    assign core_out = W'($unsigned($signed({fill, core_in}) >>> amount));
    assign y        = (kind == SH_LEFT) ? core_rev : core_out;
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv
    import int_alu_pkg::*;
#(
    parameter int W = XLEN_DEFAULT
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_div,
    output logic [W-1:0] y
);
    logic [W-1:0] prod_lo;
    logic         a_neg, b_neg, b_zero;
    logic [W-1:0] a_mag, b_mag, b_safe, q_mag, q_signed;

    // Low half of a signed product equals the low half of the product
    // of the sign-extended operands taken as unsigned
    assign prod_lo = W'({{W{a[W-1]}}, a} * {{W{b[W-1]}}, b});

    assign a_neg    = a[W-1];
    assign b_neg    = b[W-1];
    assign b_zero   = (b == '0);
    assign a_mag    = a_neg ? (~a + 1'b1) : a;
    assign b_mag    = b_neg ? (~b + 1'b1) : b;
    assign b_safe   = b_zero ? {{(W-1){1'b0}}, 1'b1} : b_mag;
    assign q_mag    = a_mag / b_safe;
    // Magnitude quotient of the minimum by one is 2^(W-1), which is the
    // minimum again: the overflow case needs no extra path
    assign q_signed = (a_neg ^ b_neg) ? (~q_mag + 1'b1) : q_mag;

    always_comb begin
        if (!do_div)     y = prod_lo;
        else if (b_zero) y = '1;
        else             y = q_signed;
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int XLEN = XLEN_DEFAULT,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [3:0]      op_i,
    output logic [XLEN-1:0] y_o
);
    alu_op_e      op;
    logic [XLEN-1:0] sum, shifted, md_res;
    cmp_flags_t   flags;
    shift_kind_e  sh_kind;

    assign op = alu_op_e'(op_i);

    always_comb begin
        case (op)
            OP_SRL:  sh_kind = SH_LOGIC;
            OP_SRA:  sh_kind = SH_ARITH;
            default: sh_kind = SH_LEFT;
        endcase
    end

    alu_addsub #(.W(XLEN)) u_addsub (
        .a     (a_i),
        .b     (b_i),
        .sub   (needs_subtract(op)),
        .sum   (sum),
        .flags (flags)
    );

    alu_shift #(.W(XLEN)) u_shift (
        .a      (a_i),
        .amount (b_i[SHW-1:0]),
        .kind   (sh_kind),
        .y      (shifted)
    );

    alu_muldiv #(.W(XLEN)) u_muldiv (
        .a      (a_i),
        .b      (b_i),
        .do_div (op == OP_DIV),
        .y      (md_res)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_SUB:          y_o = sum;
            OP_SLL, OP_SRL, OP_SRA:  y_o = shifted;
            OP_SLT:  y_o = {{(XLEN-1){1'b0}}, flags.lt_signed};
            OP_SLTU: y_o = {{(XLEN-1){1'b0}}, flags.lt_unsigned};
            OP_XOR:  y_o = a_i ^ b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_AND:  y_o = a_i & b_i;
            OP_MUL, OP_DIV:          y_o = md_res;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [3:0]   op_i,
    input logic [W-1:0] y_o
);
    localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        if (op_i == 4'd0)
            AST_ADD_INVERSE: assert (y_o - b_i == a_i) else $error("add inverse");  // R1
        if (op_i == 4'd1)
            AST_SUB_INVERSE: assert (y_o + b_i == a_i) else $error("sub inverse");  // R2
        if ((op_i == 4'd2 || op_i == 4'd6) && b_i[SHW-1:0] == '0)
            AST_SHIFT_ZERO: assert (y_o == a_i) else $error("zero shift");  // R3
        if (op_i == 4'd7 && a_i[W-1])
            AST_SRA_SIGN: assert (y_o[W-1]) else $error("sra sign");  // R4
        if (op_i == 4'd3 || op_i == 4'd4)
            AST_SLT_BOOL: assert (y_o[W-1:1] == '0) else $error("slt width");  // R5
        if (op_i == 4'd10 && b_i == ONE)
            AST_MUL_ONE: assert (y_o == a_i) else $error("mul by one");  // R8
        if (op_i == 4'd11 && b_i == '0)
            AST_DIV_ZERO: assert (y_o == '1) else $error("div zero");  // R10
        if (op_i == 4'd11 && a_i == MIN_VAL && b_i == '1)
            AST_DIV_OVF: assert (y_o == MIN_VAL) else $error("div overflow");  // R11
        if (op_i >= 4'd12)
            AST_UNUSED_ZERO: assert (y_o == '0) else $error("unused op");  // R12
    end
endmodule

bind int_alu int_alu_chk #(.W(XLEN)) u_chk (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (op_i),
    .y_o  (y_o)
);

// File: tb/int_alu_tb.sv
`timescale 1ns/1ps
module int_alu_tb;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  op;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic [31:0] a_i = '0, b_i = '0;
    logic [3:0]  op_i = '0;
    logic [31:0] y_o;

    item_t q[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    always #2.5 clk = ~clk;

    int_alu u_dut (.a_i(a_i), .b_i(b_i), .op_i(op_i), .y_o(y_o));

    function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic [3:0] op);
        longint prod;
        int     sa, sb;
        sa = int'(a);
        sb = int'(b);
        case (op)
            4'd0:  return a + b;
            4'd1:  return a - b;
            4'd2:  return a << b[4:0];
            4'd3:  return (sa < sb) ? 32'd1 : 32'd0;
            4'd4:  return (a < b) ? 32'd1 : 32'd0;
            4'd5:  return a ^ b;
            4'd6:  return a >> b[4:0];
            4'd7:  return 32'(sa >>> b[4:0]);
            4'd8:  return a | b;
            4'd9:  return a & b;
            4'd10: begin prod = longint'(sa) * longint'(sb); return prod[31:0]; end
            4'd11: begin
                if (b == 32'd0) return 32'hFFFF_FFFF;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
                return 32'(sa / sb);
            end
            default: return 32'd0;
        endcase
    endfunction

    // Driver: applies one vector after a rising edge and queues its expectation
    task automatic drive(logic [31:0] a, logic [31:0] b, logic [3:0] op, string tag);
        item_t it;
        @(posedge clk);
        it.a = a; it.b = b; it.op = op; it.tag = tag;
        it.exp = model(a, b, op);
        a_i  <= a;
        b_i  <= b;
        op_i <= op;
        q.push_back(it);
    endtask

    task automatic drive_exp(logic [31:0] a, logic [31:0] b, logic [3:0] op,
                             logic [31:0] exp, string tag);
        item_t it;
        @(posedge clk);
        it.a = a; it.b = b; it.op = op; it.tag = tag; it.exp = exp;
        a_i  <= a;
        b_i  <= b;
        op_i <= op;
        q.push_back(it);
    endtask

    // Monitor: compares on the falling edge, half a period after the inputs change
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_vec++;
                if (y_o !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                             it.tag, it.op, it.a, it.b, y_o, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // Idle state: zero operands under code 0 give zero
        drive_exp(32'd0, 32'd0, 4'd0, 32'd0, "R1");

        // R1 add, including wrap past 2^32
        drive_exp(32'd5, 32'd7, 4'd0, 32'd12, "R1");
        drive_exp(32'hFFFF_FFFF, 32'd1, 4'd0, 32'd0, "R1");
        drive(32'h7FFF_FFFF, 32'h0000_0001, 4'd0, "R1");

        // R2 subtract, including borrow wrap
        drive_exp(32'd3, 32'd5, 4'd1, 32'hFFFF_FFFE, "R2");
        drive(32'h8000_0000, 32'd1, 4'd1, "R2");

        // R3 left and logical right shifts; junk in b[31:5] must not matter
        drive_exp(32'h0000_0001, 32'hFFFF_FFE4, 4'd2, 32'h0000_0010, "R3");
        drive_exp(32'h8000_0001, 32'd31, 4'd2, 32'h8000_0000, "R3");
        drive_exp(32'h8000_0000, 32'h0000_0020, 4'd6, 32'h8000_0000, "R3");
        drive_exp(32'h8000_0000, 32'd31, 4'd6, 32'h0000_0001, "R3");

        // R4 arithmetic right shift fills with the sign
        drive_exp(32'h8000_0000, 32'd4, 4'd7, 32'hF800_0000, "R4");
        drive_exp(32'h4000_0000, 32'hFFFF_FFE1, 4'd7, 32'h2000_0000, "R4");
        drive_exp(32'hF000_0000, 32'd31, 4'd7, 32'hFFFF_FFFF, "R4");

        // R5 / R6 pairs where signed and unsigned order disagree
        drive_exp(32'hFFFF_FFFF, 32'd1, 4'd3, 32'd1, "R5");
        drive_exp(32'd1, 32'hFFFF_FFFF, 4'd3, 32'd0, "R5");
        drive_exp(32'd4, 32'd4, 4'd3, 32'd0, "R5");
        drive_exp(32'hFFFF_FFFF, 32'd1, 4'd4, 32'd0, "R6");
        drive_exp(32'd1, 32'hFFFF_FFFF, 4'd4, 32'd1, "R6");

        // R7 bitwise
        drive_exp(32'hF0F0_1234, 32'hFF00_00FF, 4'd5, 32'h0FF0_12CB, "R7");
        drive_exp(32'hF0F0_1234, 32'hFF00_00FF, 4'd8, 32'hFFF0_12FF, "R7");
        drive_exp(32'hF0F0_1234, 32'hFF00_00FF, 4'd9, 32'hF000_0034, "R7");

        // R8 signed multiply, low word, all sign combinations
        drive_exp(32'hFFFF_FFFD, 32'd7, 4'd10, 32'hFFFF_FFEB, "R8");
        drive_exp(32'hFFFF_FFFD, 32'hFFFF_FFF9, 4'd10, 32'd21, "R8");
        drive_exp(32'h0001_0000, 32'h0001_0000, 4'd10, 32'd0, "R8");
        drive(32'h8000_0000, 32'hFFFF_FFFF, 4'd10, "R8");

        // R9 divide rounds toward zero
        drive_exp(32'd7, 32'd2, 4'd11, 32'd3, "R9");
        drive_exp(32'hFFFF_FFF9, 32'd2, 4'd11, 32'hFFFF_FFFD, "R9");
        drive_exp(32'd7, 32'hFFFF_FFFE, 4'd11, 32'hFFFF_FFFD, "R9");
        drive_exp(32'hFFFF_FFF9, 32'hFFFF_FFFE, 4'd11, 32'd3, "R9");
        drive_exp(32'h8000_0000, 32'd1, 4'd11, 32'h8000_0000, "R9");

        // R10 divide by zero
        drive_exp(32'd123, 32'd0, 4'd11, 32'hFFFF_FFFF, "R10");
        drive_exp(32'h8000_0000, 32'd0, 4'd11, 32'hFFFF_FFFF, "R10");

        // R11 overflowing quotient
        drive_exp(32'h8000_0000, 32'hFFFF_FFFF, 4'd11, 32'h8000_0000, "R11");

        // R12 unused codes
        for (int c = 12; c < 16; c++)
            drive_exp(32'hDEAD_BEEF, 32'h1234_5678, 4'(c), 32'd0, "R12");

        // Mixed sweep over every code with pseudo-random operands
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra, rb;
            logic [3:0]  rop;
            ra  = $urandom;
            rb  = (n % 7 == 0) ? 32'd0 : $urandom;
            rop = 4'(n % 16);
            case (rop)
                4'd0:  drive(ra, rb, rop, "R1");
                4'd1:  drive(ra, rb, rop, "R2");
                4'd2, 4'd6: drive(ra, rb, rop, "R3");
                4'd7:  drive(ra, rb, rop, "R4");
                4'd3:  drive(ra, rb, rop, "R5");
                4'd4:  drive(ra, rb, rop, "R6");
                4'd5, 4'd8, 4'd9: drive(ra, rb, rop, "R7");
                4'd10: drive(ra, rb, rop, "R8");
                4'd11: drive(ra, rb, rop, (rb == 32'd0) ? "R10" : "R9");
                default: drive(ra, rb, rop, "R12");
            endcase
        end

        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule